// File: doc/BRIEF.md
# Multi-Pipe Writeback Arbiter with Result Composer

Several execution pipes finish at unpredictable times, so two or more of them can hand over a result in the same cycle. This block gives every pipe its own request queue. Each cycle a round-robin arbiter picks one non-empty queue and pops its head entry. The entry then becomes a single register-file write request on the output.

On the way out, a memory-load result is composed lane by lane. The addressed byte or halfword is moved into the low bits and is either sign- or zero-extended to 32 bits. A byte-write mask is built so that only the bytes the load owns are written. Only lane 0 of a scalar result is written. A vector result writes the lanes its lane mask enables.

The write request carries the owning thread, the destination register, the lane mask, the byte enables and the composed data. It also carries a one-hot release bitmap that the thread's scoreboard uses to free the destination register. Each queue raises an almost-full flag four entries before it is really full. The issue scheduler uses this flag as back-pressure, so that operations already past the issue point still find room.

Top module: `wb_collision_arbiter`

## Requirements
- R1: A pipe with `pipe_valid` high at a rising edge has its entry stored in that pipe's queue. The entry holds data, lane mask, destination, thread and load controls. No entry is lost while the producer respects almost-full.
- R2: At most one entry is written back per cycle. Arbitration starts at the pipe after the last pipe granted, and pipe 0 is first after reset. An entry accepted at edge k appears on the write port after edge k+1 if its queue wins at that point.
- R3: `pipe_almost_full[p]` is high exactly while queue p holds at least QUEUE_DEPTH-4 entries (4 of 8 by default).
- R4: A scalar entry (`pipe_is_vector`=0) writes lane 0 only: `wr_lane_mask`=1. A vector entry writes exactly the lanes set in its lane mask. Lanes that are not written have zero byte enables.
- R5: Load size code 2 is a byte load. The byte at offset bits [1:0] of the raw lane word goes into bits [7:0], and the byte enable of each written lane is 4'b0001.
- R6: Load size code 1 is a halfword load. Offset bit 1 selects the upper (1) or lower (0) halfword, which goes into bits [15:0]. The byte enable is 4'b0011.
- R7: Sub-word loads are sign-extended when `pipe_ld_signed`=1 and zero-extended otherwise.
- R8: Size code 0 (and 3) is a full-word or non-load result. The data passes through unchanged and the byte enable of each written lane is 4'b1111.
- R9: Each write carries `sb_release` with only the bit at index `wr_dst` set. The bitmap is all zero when `wr_valid` is low.
- R10: Synchronous active-low reset empties every queue, clears `wr_valid` and all almost-full flags, and puts the arbiter pointer back so that pipe 0 is first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pipe_valid | input | NUM_PIPES | Per-pipe result valid |
| pipe_data | input | NUM_PIPES*LANES*DATA_W | Per-pipe raw lane data |
| pipe_dst | input | NUM_PIPES*REG_ADDR_W | Per-pipe destination register |
| pipe_thread | input | NUM_PIPES*THREAD_W | Per-pipe owning thread |
| pipe_is_vector | input | NUM_PIPES | 1 = vector result |
| pipe_lane_mask | input | NUM_PIPES*LANES | Per-pipe lane enable mask |
| pipe_ld_size | input | NUM_PIPES*2 | 0/3 word, 1 halfword, 2 byte |
| pipe_ld_signed | input | NUM_PIPES | Sign-extend sub-word loads |
| pipe_ld_offset | input | NUM_PIPES*2 | Low address bits of the load |
| pipe_almost_full | output | NUM_PIPES | Back-pressure to the issue scheduler |
| wr_valid | output | 1 | Write request valid |
| wr_thread | output | THREAD_W | Thread owning the write |
| wr_dst | output | REG_ADDR_W | Destination register |
| wr_is_vector | output | 1 | Vector write |
| wr_lane_mask | output | LANES | Lanes written |
| wr_byte_en | output | LANES*DATA_W/8 | Byte enables per lane |
| wr_data | output | LANES*DATA_W | Composed data per lane |
| sb_release | output | 2**REG_ADDR_W | Scoreboard release bitmap |

## Verification
An entry pushed at one rising edge is in its queue after that edge and, if no other queue competes, is on the write port after the next edge. The bench drives inputs on the falling edge and samples 1 ns after the second rising edge. Almost-full changes on the same edge that changes the occupancy, so it is sampled just after that edge. When all pipes are pushed at once, the bench reads one grant per cycle and compares the order with the rotation it expects. An occupancy ramp is started from reset, so the bench knows the count in every queue after each edge.

// File: rtl/wb_pkg.sv
// Shared encodings for the writeback arbiter.
package wb_pkg;
    // Load size code; code 3 is treated like a full word.
    typedef enum logic [1:0] {
        LD_WORD = 2'd0,
        LD_HALF = 2'd1,
        LD_BYTE = 2'd2,
        LD_RSVD = 2'd3
    } ld_size_e;
endpackage

// File: rtl/wb_req_queue.sv
// Request queue for one execution pipe.
// Assumes DEPTH is a power of two. A push that arrives while the queue
// is full is only legal together with a pop; the producer must honour
// almost_full. almost_full rises MARGIN entries before the queue is full.
module wb_req_queue #(
    parameter int WIDTH  = 8,
    parameter int DEPTH  = 8,
    parameter int MARGIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic             almost_full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W:0] AF_LEVEL = (PTR_W+1)'(DEPTH - MARGIN);
    localparam logic [PTR_W:0] FULL_LEVEL = (PTR_W+1)'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [PTR_W:0]   count;

    // Storage write, no reset needed for data.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + (PTR_W+1)'(push) - (PTR_W+1)'(pop);
        end
    end

    assign head        = mem[rd_ptr];
    assign empty       = (count == '0);
    assign full        = (count == FULL_LEVEL);
    assign almost_full = (count >= AF_LEVEL);

    // R1: no entry dropped by a push into a full queue
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |-> pop);
    // R2: the arbiter never pops an empty queue
    p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R3: back-pressure always precedes a full queue
    p_af_before_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> almost_full);
endmodule

// File: rtl/wb_rr_arbiter.sv
// Round-robin arbiter: grants one requester per cycle, starting the
// search at the requester after the last one granted. After reset the
// search starts at requester 0.
module wb_rr_arbiter #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [IDX_W-1:0] last_q;

    // Pick the first requester after last_q, wrapping around.
    always_comb begin
        logic found;
        grant = '0;
        found = 1'b0;
        for (int i = 1; i <= N; i++) begin
            int idx;
            idx = (int'(last_q) + i) % N;
            if (!found && req[idx]) begin
                grant[idx] = 1'b1;
                found      = 1'b1;
            end
        end
    end

    // Remember the last granted requester.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= IDX_W'(N - 1);
        end else begin
            for (int i = 0; i < N; i++) begin
                if (grant[i]) last_q <= IDX_W'(i);
            end
        end
    end

    // R2: a single grant per cycle
    p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R2: work conserving
    p_grant_when_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (|grant));
    // R2: the winner is skipped next cycle if someone else waits
    p_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |=> (((req & ~$past(grant)) != '0) -> ((grant & $past(grant)) == '0)));
endmodule

// File: rtl/wb_lane_composer.sv
// Composes one 32-bit lane of a load result: aligns a byte or halfword
// selected by the low address bits into the low bits, extends it, and
// produces the lane's byte-write enables. Full-word results pass through.
// Assumes DATA_W is 32.
module wb_lane_composer
    import wb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]   raw,
    input  ld_size_e            size,
    input  logic                sgn,
    input  logic [1:0]          offset,
    output logic [DATA_W-1:0]   data,
    output logic [DATA_W/8-1:0] be
);
    localparam int BYTES = DATA_W / 8;

    logic [7:0]  sel_byte;
    logic [15:0] sel_half;

    assign sel_byte = raw[8*offset +: 8];
    assign sel_half = raw[16*offset[1] +: 16];

    // Align, extend and mask by load size.
    always_comb begin
        case (size)
            LD_BYTE: begin
                data = {{(DATA_W-8){sgn & sel_byte[7]}}, sel_byte};
                be   = BYTES'(1);
            end
            LD_HALF: begin
                data = {{(DATA_W-16){sgn & sel_half[15]}}, sel_half};
                be   = BYTES'(3);
            end
            default: begin
                data = raw;
                be   = '1;
            end
        endcase
    end
endmodule

// File: rtl/wb_collision_arbiter.sv
// Writeback collision arbiter. One request queue per execution pipe,
// a round-robin pick of one queue per cycle, lane composition of the
// winner and a registered register-file write request with a scoreboard
// release bitmap. Assumes the issue scheduler stops issuing into a pipe
// whose almost-full flag is high.
module wb_collision_arbiter
    import wb_pkg::*;
#(
    parameter int NUM_PIPES   = 4,
    parameter int QUEUE_DEPTH = 8,
    parameter int AF_MARGIN   = 4,
    parameter int LANES       = 16,
    parameter int DATA_W      = 32,
    parameter int REG_ADDR_W  = 6,
    parameter int THREAD_W    = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_PIPES-1:0]               pipe_valid,
    input  logic [NUM_PIPES*LANES*DATA_W-1:0]  pipe_data,
    input  logic [NUM_PIPES*REG_ADDR_W-1:0]    pipe_dst,
    input  logic [NUM_PIPES*THREAD_W-1:0]      pipe_thread,
    input  logic [NUM_PIPES-1:0]               pipe_is_vector,
    input  logic [NUM_PIPES*LANES-1:0]         pipe_lane_mask,
    input  logic [NUM_PIPES*2-1:0]             pipe_ld_size,
    input  logic [NUM_PIPES-1:0]               pipe_ld_signed,
    input  logic [NUM_PIPES*2-1:0]             pipe_ld_offset,
    output logic [NUM_PIPES-1:0]               pipe_almost_full,
    output logic                               wr_valid,
    output logic [THREAD_W-1:0]                wr_thread,
    output logic [REG_ADDR_W-1:0]              wr_dst,
    output logic                               wr_is_vector,
    output logic [LANES-1:0]                   wr_lane_mask,
    output logic [LANES*DATA_W/8-1:0]          wr_byte_en,
    output logic [LANES*DATA_W-1:0]            wr_data,
    output logic [(1<<REG_ADDR_W)-1:0]         sb_release
);
    localparam int BYTES   = DATA_W / 8;
    localparam int LDATA_W = LANES * DATA_W;
    localparam int NREGS   = 1 << REG_ADDR_W;
    localparam int ENTRY_W = LDATA_W + LANES + REG_ADDR_W + THREAD_W + 1 + 2 + 1 + 2;

    logic [ENTRY_W-1:0]   entry_in [NUM_PIPES];
    logic [ENTRY_W-1:0]   heads    [NUM_PIPES];
    logic [NUM_PIPES-1:0] q_empty, q_full, grant;
    logic [ENTRY_W-1:0]   sel_entry;

    logic [LDATA_W-1:0]    h_data;
    logic [LANES-1:0]      h_mask;
    logic [REG_ADDR_W-1:0] h_dst;
    logic [THREAD_W-1:0]   h_thread;
    logic                  h_vec, h_sgn;
    logic [1:0]            h_size, h_off;

    logic [LANES-1:0]       lane_en;
    logic [LDATA_W-1:0]     comp_data;
    logic [LANES*BYTES-1:0] comp_be;

    // One queue per pipe.
    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
        assign entry_in[p] = {pipe_data[p*LDATA_W +: LDATA_W],
                              pipe_lane_mask[p*LANES +: LANES],
                              pipe_dst[p*REG_ADDR_W +: REG_ADDR_W],
                              pipe_thread[p*THREAD_W +: THREAD_W],
                              pipe_is_vector[p],
                              pipe_ld_size[p*2 +: 2],
                              pipe_ld_signed[p],
                              pipe_ld_offset[p*2 +: 2]};

        wb_req_queue #(
            .WIDTH (ENTRY_W),
            .DEPTH (QUEUE_DEPTH),
            .MARGIN(AF_MARGIN)
        ) u_queue (
            .clk        (clk),
            .rst_n      (rst_n),
            .push       (pipe_valid[p]),
            .push_data  (entry_in[p]),
            .pop        (grant[p]),
            .head       (heads[p]),
            .empty      (q_empty[p]),
            .full       (q_full[p]),
            .almost_full(pipe_almost_full[p])
        );
    end

    wb_rr_arbiter #(.N(NUM_PIPES)) u_arb (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (~q_empty),
        .grant(grant)
    );

    // Select the granted head entry (grant is one-hot).
    always_comb begin
        sel_entry = '0;
        for (int p = 0; p < NUM_PIPES; p++) begin
            if (grant[p]) sel_entry = sel_entry | heads[p];
        end
    end

    assign {h_data, h_mask, h_dst, h_thread, h_vec, h_size, h_sgn, h_off} = sel_entry;

    // Lane composition of the selected entry.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [BYTES-1:0] lane_be;

        assign lane_en[l] = h_vec ? h_mask[l] : (l == 0);

        wb_lane_composer #(.DATA_W(DATA_W)) u_comp (
            .raw   (h_data[l*DATA_W +: DATA_W]),
            .size  (ld_size_e'(h_size)),
            .sgn   (h_sgn),
            .offset(h_off),
            .data  (comp_data[l*DATA_W +: DATA_W]),
            .be    (lane_be)
        );

        assign comp_be[l*BYTES +: BYTES] = lane_en[l] ? lane_be : '0;
    end

    // Register the write request and the scoreboard release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid     <= 1'b0;
            wr_thread    <= '0;
            wr_dst       <= '0;
            wr_is_vector <= 1'b0;
            wr_lane_mask <= '0;
            wr_byte_en   <= '0;
            wr_data      <= '0;
            sb_release   <= '0;
        end else begin
            wr_valid   <= |grant;
            sb_release <= (|grant) ? (NREGS'(1) << h_dst) : '0;
            if (|grant) begin
                wr_thread    <= h_thread;
                wr_dst       <= h_dst;
                wr_is_vector <= h_vec;
                wr_lane_mask <= lane_en;
                wr_byte_en   <= comp_be;
                wr_data      <= comp_data;
            end
        end
    end

    // R2: a write only follows a cycle with a non-empty queue
    p_write_has_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(~&q_empty));
    // R9: exactly one register released per write
    p_release_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ($countones(sb_release) == 1));
    // R9: no release without a write
    p_release_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |-> (sb_release == '0));
    // R4: a scalar write touches lane 0 only
    p_scalar_lane0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_is_vector) |-> (wr_lane_mask == LANES'(1)));
    for (genvar l = 0; l < LANES; l++) begin : g_chk
        // R4: disabled lanes carry no byte enables
        p_be_in_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_valid && !wr_lane_mask[l]) |-> (wr_byte_en[l*BYTES +: BYTES] == '0));
    end
endmodule

// File: tb/tb_wb_collision_arbiter.sv
module tb_wb_collision_arbiter;
    localparam int P = 4, L = 16, DW = 32, RW = 6, TW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [P-1:0]      pipe_valid = '0, pipe_is_vector = '0, pipe_ld_signed = '0;
    logic [P*L*DW-1:0] pipe_data = '0;
    logic [P*RW-1:0]   pipe_dst = '0;
    logic [P*TW-1:0]   pipe_thread = '0;
    logic [P*L-1:0]    pipe_lane_mask = '0;
    logic [P*2-1:0]    pipe_ld_size = '0, pipe_ld_offset = '0;
    logic [P-1:0]      pipe_almost_full;
    logic              wr_valid, wr_is_vector;
    logic [TW-1:0]     wr_thread;
    logic [RW-1:0]     wr_dst;
    logic [L-1:0]      wr_lane_mask;
    logic [L*4-1:0]    wr_byte_en;
    logic [L*DW-1:0]   wr_data;
    logic [63:0]       sb_release;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wb_collision_arbiter dut (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [1:0]  pipe;
        logic        vec;
        logic [15:0] mask;
        logic [1:0]  size;
        logic        sgn;
        logic [1:0]  off;
        logic [31:0] exp0;
        logic [3:0]  be0;
    } vec_t;

    localparam logic [31:0] RAW = 32'h80F1_7F82;
    localparam int NV = 11;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 1'b0, 16'h0000, 2'd0, 1'b0, 2'd0, 32'h80F17F82, 4'hF}, // R8
        '{2'd1, 1'b0, 16'h0000, 2'd2, 1'b0, 2'd0, 32'h00000082, 4'h1}, // R5 R7
        '{2'd2, 1'b0, 16'h0000, 2'd2, 1'b1, 2'd0, 32'hFFFFFF82, 4'h1}, // R5 R7
        '{2'd3, 1'b0, 16'h0000, 2'd2, 1'b1, 2'd1, 32'h0000007F, 4'h1}, // R5
        '{2'd0, 1'b0, 16'h0000, 2'd2, 1'b1, 2'd3, 32'hFFFFFF80, 4'h1}, // R5
        '{2'd1, 1'b0, 16'h0000, 2'd1, 1'b1, 2'd2, 32'hFFFF80F1, 4'h3}, // R6 R7
        '{2'd2, 1'b0, 16'h0000, 2'd1, 1'b0, 2'd2, 32'h000080F1, 4'h3}, // R6 R7
        '{2'd3, 1'b0, 16'h0000, 2'd1, 1'b1, 2'd0, 32'h00007F82, 4'h3}, // R6
        '{2'd0, 1'b1, 16'hA5A5, 2'd0, 1'b0, 2'd0, 32'h80F17F82, 4'hF}, // R4 R8
        '{2'd1, 1'b1, 16'h0003, 2'd2, 1'b1, 2'd2, 32'hFFFFFFF1, 4'h1}, // R4 R5
        '{2'd2, 1'b0, 16'hFFFF, 2'd3, 1'b1, 2'd1, 32'h80F17F82, 4'hF}  // R8 code 3
    };

    task automatic clear_inputs();
        pipe_valid = '0; pipe_is_vector = '0; pipe_ld_signed = '0;
        pipe_data = '0; pipe_dst = '0; pipe_thread = '0;
        pipe_lane_mask = '0; pipe_ld_size = '0; pipe_ld_offset = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        clear_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        #1;
        // R10: reset state
        check("R10 wr_valid", 64'(wr_valid), 64'd0);
        check("R10 almost_full", 64'(pipe_almost_full), 64'd0);
        check("R9 release idle", sb_release, 64'd0);

        // Table of composition vectors, one push each.
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            int p;
            logic [L*4-1:0] exp_be;
            logic ok;
            v = TBL[i];
            p = int'(v.pipe);
            @(negedge clk);
            clear_inputs();
            pipe_valid[p] = 1'b1;
            pipe_is_vector[p] = v.vec;
            pipe_lane_mask[p*L +: L] = v.mask;
            pipe_ld_size[p*2 +: 2] = v.size;
            pipe_ld_signed[p] = v.sgn;
            pipe_ld_offset[p*2 +: 2] = v.off;
            pipe_dst[p*RW +: RW] = RW'(i * 5 + 3);
            pipe_thread[p*TW +: TW] = TW'(i);
            for (int l = 0; l < L; l++) pipe_data[p*L*DW + l*DW +: DW] = RAW;
            @(posedge clk);
            #1;
            clear_inputs();
            @(posedge clk);
            #1;
            exp_be = '0;
            for (int l = 0; l < L; l++) begin
                if (v.vec ? v.mask[l] : (l == 0)) exp_be[l*4 +: 4] = v.be0;
            end
            check("R2 wr_valid one cycle after push", 64'(wr_valid), 64'd1);
            check("R1 dst carried", 64'(wr_dst), 64'(i * 5 + 3));
            check("R1 thread carried", 64'(wr_thread), 64'(i % 4));
            check("R4 lane mask", 64'(wr_lane_mask), v.vec ? 64'(v.mask) : 64'd1);
            check("R4/R5/R6/R8 byte enables", wr_byte_en, exp_be);
            check("R5/R6/R7/R8 lane0 data", 64'(wr_data[DW-1:0]), 64'(v.exp0));
            ok = 1'b1;
            for (int l = 0; l < L; l++) begin
                if (exp_be[l*4 +: 4] != 4'h0 && wr_data[l*DW +: DW] !== v.exp0) ok = 1'b0;
            end
            check("R4 enabled lanes data", 64'(ok), 64'd1);
            check("R9 release bitmap", sb_release, 64'd1 << (i * 5 + 3));
        end

        // R2: all pipes at once after reset, grants in order 0,1,2,3
        do_reset();
        @(negedge clk);
        pipe_valid = '1;
        for (int p = 0; p < P; p++) pipe_dst[p*RW +: RW] = RW'(40 + p);
        @(posedge clk);
        #1;
        clear_inputs();
        for (int k = 0; k < P; k++) begin
            @(posedge clk);
            #1;
            check("R2 rr valid", 64'(wr_valid), 64'd1);
            check("R2 rr order", 64'(wr_dst), 64'(40 + k));
        end
        @(posedge clk);
        #1;
        check("R2 idle after drain", 64'(wr_valid), 64'd0);

        // R3/R1: occupancy ramp with every pipe pushing each cycle
        do_reset();
        begin
            int seen;
            seen = 0;
            @(negedge clk);
            pipe_valid = '1;
            for (int e = 1; e <= 5; e++) begin
                @(posedge clk);
                #1;
                if (wr_valid) seen++;
                if (e == 4) check("R3 only pipe 3 at 4 entries", 64'(pipe_almost_full), 64'h8);
                if (e == 5) check("R3 all at 4 entries", 64'(pipe_almost_full), 64'hF);
            end
            clear_inputs();
            for (int e = 0; e < 25; e++) begin
                @(posedge clk);
                #1;
                if (wr_valid) seen++;
            end
            check("R1 no entry lost", 64'(seen), 64'd20);
            check("R3 flags clear after drain", 64'(pipe_almost_full), 64'd0);
            check("R2 idle", 64'(wr_valid), 64'd0);
        end

        // R10: reset with loaded queues
        @(negedge clk);
        pipe_valid = '1;
        @(posedge clk);
        #1;
        @(posedge clk);
        #1;
        @(negedge clk);
        clear_inputs();
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R10 valid cleared", 64'(wr_valid), 64'd0);
        check("R10 flags cleared", 64'(pipe_almost_full), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        @(posedge clk);
        #1;
        check("R10 queues emptied", 64'(wr_valid), 64'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule